// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Output

This block is a first-in first-out buffer whose write side and read side run on independent, free-running clocks. Each side qualifies its operation with its own enable. Words go into an internal dual-port register array at a write index that the block keeps for itself. They come out in the same order at a read index that the block also keeps for itself. No address is visible at the ports. Each index is passed to the other domain in Gray code through a two-flop synchronizer. Each domain then derives its own flags and its own fill count.

A static mode pin selects the output behaviour. In pull mode a word reaches the data output only on an enabled read clock. In fall-through mode the oldest stored word is presented on its own, and a read enable consumes it. FULL and EMPTY assert on the very edge that causes the condition. They release only after the crossing latency. Two further outputs warn early: almost-full compares the write-side fill against a programmable level, and almost-empty compares the read-side fill against another programmable level. The mode pin and both levels are meant to be held steady while the FIFO is in use.

Top module: `fifo_dc`

## Requirements
- R1: Every accepted word leaves the read port exactly once, in write order, with its value unchanged, in both output modes.
- R2: `full_o` rises on the write-clock edge that stores the word making the count equal to the depth (16 by default). It stays low while fewer words are held.
- R3: `empty_o` rises on the read-clock edge that consumes the last word. In pull mode this is the edge of the read that takes the last stored word. In fall-through mode it is the edge where the word shown on `rdata_o` is consumed and no further word is stored.
- R4: A write enable while `full_o` is high stores nothing and does not move the write index. The FIFO then still holds exactly the depth in words, with the original values.
- R5: In pull mode, a read enable while `empty_o` is high leaves `rdata_o` and the read index unchanged.
- R6: With `fwft_i` = 0 (pull mode), after a write into an empty FIFO `empty_o` falls, but `rdata_o` keeps its old value until a read enable is sampled high while `empty_o` is low. The word appears one read-clock edge after that read.
- R7: With `fwft_i` = 1 (fall-through mode), a word written into an empty FIFO appears on `rdata_o`, and `empty_o` falls, with `rd_en_i` held low.
- R8: In fall-through mode, `rdata_o` holds while `rd_en_i` is low. A read enable with `empty_o` low moves `rdata_o` to the next stored word on that edge.
- R9: `almost_full_o` is high exactly when the write-side fill count (words written minus words seen read through the synchronizer) is at least `af_thresh_i`.
- R10: `almost_empty_o` is high exactly when the read-side fill count is at most `ae_thresh_i`. In fall-through mode this count includes a valid word held on `rdata_o`. It is high after reset.
- R11: Indices cross between domains as Gray code, changing one bit per step, through two-flop synchronizers. After activity in the other domain, `full_o` and `empty_o` release within 6 cycles of their own clock.
- R12: After reset, `empty_o` = 1, `full_o` = 0, `almost_empty_o` = 1, `almost_full_o` = 0 and `rdata_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock, free-running |
| wrst_ni | input | 1 | Write-domain asynchronous reset, active low |
| wr_en_i | input | 1 | Write enable |
| wdata_i | input | DW | Word to store |
| af_thresh_i | input | AW+1 | Almost-full level |
| full_o | output | 1 | No free location |
| almost_full_o | output | 1 | Fill count at or above the almost-full level |
| rclk_i | input | 1 | Read clock, free-running |
| rrst_ni | input | 1 | Read-domain asynchronous reset, active low |
| fwft_i | input | 1 | 0 = pull mode, 1 = fall-through mode (static) |
| rd_en_i | input | 1 | Read enable |
| ae_thresh_i | input | AW+1 | Almost-empty level |
| rdata_o | output | DW | Output word |
| empty_o | output | 1 | No word available to read |
| almost_empty_o | output | 1 | Fill count at or below the almost-empty level |

## Verification
The hardest coincidence is a read that frees a location in the same cycle as a write that fills the FIFO, or a write that lands in the cycle where the last word is taken. Then a flag that has just asserted must release again through the synchronizer while the other side keeps working. This is provoked by streaming phases in which both enables toggle at random, with unrelated clock periods. One phase has the writer much faster than the reader, so the FIFO sits at full. Another has the reader faster, so it sits at empty. A queue-based scoreboard compares every word leaving the read port against the order of accepted writes. Directed phases pin the exact edges at which FULL, EMPTY and the almost flags change.

// File: rtl/fifo_dc_pkg.sv
package fifo_dc_pkg;
  typedef enum logic {
    OUT_PULL = 1'b0,
    OUT_PUSH = 1'b1
  } out_mode_e;
endpackage

// File: rtl/fifo_dc_sync.sv
module fifo_dc_sync #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/fifo_dc_wr_ctrl.sv
module fifo_dc_wr_ctrl #(
  parameter int AW = 4
) (
  input  logic          wclk_i,
  input  logic          wrst_ni,
  input  logic          wr_en_i,
  input  logic [AW:0]   rgray_sync_i,
  input  logic [AW:0]   af_thresh_i,
  output logic [AW-1:0] waddr_o,
  output logic          wr_ok_o,
  output logic [AW:0]   wgray_o,
  output logic          full_o,
  output logic          almost_full_o
);
  localparam int PW = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] LAST_FREE = PW'(DEPTH - 1);
  localparam logic [PW-1:0] DEPTH_V = PW'(DEPTH);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic acc;
    acc = 1'b0;
    for (int i = PW - 1; i >= 0; i--) begin
      acc    = acc ^ g[i];
      g2b[i] = acc;
    end
  endfunction

  logic [PW-1:0] wbin_q, wgray_q, wbin_nxt, wgray_nxt, rbin_sync, fill_now, fill_nxt;
  logic          full_q, af_q, full_nxt;

  assign wr_ok_o   = wr_en_i & ~full_q;
  assign wbin_nxt  = wbin_q + PW'(wr_ok_o);
  assign wgray_nxt = (wbin_nxt >> 1) ^ wbin_nxt;
  assign rbin_sync = g2b(rgray_sync_i);
  assign fill_now  = wbin_q - rbin_sync;
  assign fill_nxt  = wbin_nxt - rbin_sync;
  // full: top two bits inverted, the rest equal
  assign full_nxt  = (wgray_nxt == {~rgray_sync_i[PW-1:PW-2], rgray_sync_i[PW-3:0]});

  always_ff @(posedge wclk_i or negedge wrst_ni) begin
    if (!wrst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full_q  <= 1'b0;
      af_q    <= 1'b0;
    end else begin
      wbin_q  <= wbin_nxt;
      wgray_q <= wgray_nxt;
      full_q  <= full_nxt;
      af_q    <= (fill_nxt >= af_thresh_i);
    end
  end

  assign waddr_o       = wbin_q[AW-1:0];
  assign wgray_o       = wgray_q;
  assign full_o        = full_q;
  assign almost_full_o = af_q;

  AST_FULL_ON_TIME: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    (wr_ok_o && fill_now == LAST_FREE) |=> full_o) else $error("full late"); // R2
  AST_FULL_WRITE_IGNORED: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    (full_o && wr_en_i) |=> $stable(wbin_q)) else $error("write while full"); // R4
  AST_NO_OVERFLOW: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    fill_now <= DEPTH_V) else $error("overflow"); // R4
  AST_WGRAY_ONE_BIT: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    $countones(wgray_q ^ $past(wgray_q)) <= 1) else $error("gray step"); // R11
endmodule

// File: rtl/fifo_dc_rd_ctrl.sv
module fifo_dc_rd_ctrl
  import fifo_dc_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          rclk_i,
  input  logic          rrst_ni,
  input  logic          rd_en_i,
  input  logic          fwft_i,
  input  logic [AW:0]   wgray_sync_i,
  input  logic [AW:0]   ae_thresh_i,
  input  logic [DW-1:0] mem_word_i,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rgray_o,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic          almost_empty_o
);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic acc;
    acc = 1'b0;
    for (int i = PW - 1; i >= 0; i--) begin
      acc    = acc ^ g[i];
      g2b[i] = acc;
    end
  endfunction

  out_mode_e     mode;
  logic [PW-1:0] rbin_q, rgray_q, rbin_nxt, rgray_nxt, wbin_sync, cnt_nxt;
  logic [DW-1:0] rdata_q;
  logic          mem_empty_q, ov_q, ov_nxt, pop, ae_q;

  assign mode = out_mode_e'(fwft_i);

  // pull: pop on read; push: refill output register when empty or consumed
  always_comb begin
    if (mode == OUT_PUSH) begin
      pop    = ~mem_empty_q & (~ov_q | rd_en_i);
      ov_nxt = pop | (ov_q & ~rd_en_i);
    end else begin
      pop    = ~mem_empty_q & rd_en_i;
      ov_nxt = 1'b0;
    end
  end

  assign rbin_nxt  = rbin_q + PW'(pop);
  assign rgray_nxt = (rbin_nxt >> 1) ^ rbin_nxt;
  assign wbin_sync = g2b(wgray_sync_i);
  assign cnt_nxt   = wbin_sync - rbin_nxt + PW'(ov_nxt);

  always_ff @(posedge rclk_i or negedge rrst_ni) begin
    if (!rrst_ni) begin
      rbin_q      <= '0;
      rgray_q     <= '0;
      mem_empty_q <= 1'b1;
      ov_q        <= 1'b0;
      ae_q        <= 1'b1;
    end else begin
      rbin_q      <= rbin_nxt;
      rgray_q     <= rgray_nxt;
      mem_empty_q <= (rgray_nxt == wgray_sync_i);
      ov_q        <= ov_nxt;
      ae_q        <= (cnt_nxt <= ae_thresh_i);
    end
  end

  always_ff @(posedge rclk_i or negedge rrst_ni) begin
    if (!rrst_ni)  rdata_q <= '0;
    else if (pop)  rdata_q <= mem_word_i;
  end

  assign raddr_o        = rbin_q[AW-1:0];
  assign rgray_o        = rgray_q;
  assign rdata_o        = rdata_q;
  assign empty_o        = (mode == OUT_PUSH) ? ~ov_q : mem_empty_q;
  assign almost_empty_o = ae_q;

  AST_PULL_EMPTY_ON_TIME: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    (!fwft_i && pop && (wbin_sync - rbin_q) == PW'(1)) |=> empty_o) else $error("empty late"); // R3
  AST_PUSH_EMPTY_ON_TIME: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    (fwft_i && !empty_o && rd_en_i && mem_empty_q) |=> empty_o) else $error("empty late"); // R3
  AST_EMPTY_READ_IGNORED: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    (!fwft_i && empty_o && rd_en_i) |=> ($stable(rbin_q) && $stable(rdata_o))) else $error("read while empty"); // R5
  AST_PULL_NEEDS_READ: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    (!fwft_i && !rd_en_i) |=> $stable(rdata_o)) else $error("pull data moved"); // R6
  AST_PUSH_HOLD: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    (fwft_i && !empty_o && !rd_en_i) |=> $stable(rdata_o)) else $error("push data moved"); // R8
  AST_RGRAY_ONE_BIT: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    $countones(rgray_q ^ $past(rgray_q)) <= 1) else $error("gray step"); // R11
endmodule

// File: rtl/fifo_dc.sv
module fifo_dc #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          wclk_i,
  input  logic          wrst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW:0]   af_thresh_i,
  output logic          full_o,
  output logic          almost_full_o,
  input  logic          rclk_i,
  input  logic          rrst_ni,
  input  logic          fwft_i,
  input  logic          rd_en_i,
  input  logic [AW:0]   ae_thresh_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic          almost_empty_o
);
  localparam int PW = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] waddr, raddr;
  logic          wr_ok;
  logic [PW-1:0] wgray, rgray, wgray_in_r, rgray_in_w;

  always_ff @(posedge wclk_i) begin
    if (wr_ok) mem_q[waddr] <= wdata_i;
  end

  fifo_dc_wr_ctrl #(.AW(AW)) u_wr (
    .wclk_i        (wclk_i),
    .wrst_ni       (wrst_ni),
    .wr_en_i       (wr_en_i),
    .rgray_sync_i  (rgray_in_w),
    .af_thresh_i   (af_thresh_i),
    .waddr_o       (waddr),
    .wr_ok_o       (wr_ok),
    .wgray_o       (wgray),
    .full_o        (full_o),
    .almost_full_o (almost_full_o)
  );

  fifo_dc_sync #(.W(PW)) u_sync_r2w (
    .clk_i  (wclk_i),
    .rst_ni (wrst_ni),
    .d_i    (rgray),
    .q_o    (rgray_in_w)
  );

  fifo_dc_sync #(.W(PW)) u_sync_w2r (
    .clk_i  (rclk_i),
    .rst_ni (rrst_ni),
    .d_i    (wgray),
    .q_o    (wgray_in_r)
  );

  fifo_dc_rd_ctrl #(.AW(AW), .DW(DW)) u_rd (
    .rclk_i         (rclk_i),
    .rrst_ni        (rrst_ni),
    .rd_en_i        (rd_en_i),
    .fwft_i         (fwft_i),
    .wgray_sync_i   (wgray_in_r),
    .ae_thresh_i    (ae_thresh_i),
    .mem_word_i     (mem_q[raddr]),
    .raddr_o        (raddr),
    .rgray_o        (rgray),
    .rdata_o        (rdata_o),
    .empty_o        (empty_o),
    .almost_empty_o (almost_empty_o)
  );
endmodule

// File: tb/fifo_dc_tb_top.sv
module fifo_dc_tb_top;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic          wclk = 1'b0, rclk = 1'b0;
  logic          wrst_n = 1'b0, rrst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0, fwft = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [AW:0]   af_thr = 5'd12, ae_thr = 5'd3;
  logic          full_o, almost_full_o, empty_o, almost_empty_o;
  logic [DW-1:0] rdata_o;

  int            n_run = 0, n_fail = 0;
  logic [DW-1:0] q[$];
  logic [DW-1:0] exp_w;
  bit            pend = 0, wdone = 0, finished = 0;

  always #2.5 wclk = ~wclk;  // 200 MHz write clock
  always #3.5 rclk = ~rclk;

  fifo_dc #(.DW(DW), .AW(AW)) dut_i (
    .wclk_i(wclk), .wrst_ni(wrst_n), .wr_en_i(wr_en), .wdata_i(wdata),
    .af_thresh_i(af_thr), .full_o(full_o), .almost_full_o(almost_full_o),
    .rclk_i(rclk), .rrst_ni(rrst_n), .fwft_i(fwft), .rd_en_i(rd_en),
    .ae_thresh_i(ae_thr), .rdata_o(rdata_o), .empty_o(empty_o),
    .almost_empty_o(almost_empty_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit mode);
    wr_en = 0; rd_en = 0; fwft = mode; pend = 0; q.delete();
    wrst_n = 0; rrst_n = 0;
    repeat (3) @(negedge wclk);
    wrst_n = 1; rrst_n = 1;
    repeat (2) @(negedge rclk);
  endtask

  task automatic wr_cycle(input bit want, input logic [DW-1:0] v);
    @(negedge wclk);
    if (want && !full_o) q.push_back(v);
    wr_en = want;
    wdata = v;
  endtask

  task automatic rd_cycle(input bit want);
    @(negedge rclk);
    if (fwft) begin
      if (!empty_o) begin
        if (q.size() == 0) chk(0, "R1 extra word", int'(rdata_o), 0);
        else begin
          chk(rdata_o == q[0], "R1 order", int'(rdata_o), int'(q[0]));
          if (want) void'(q.pop_front());
        end
      end
    end else begin
      if (pend) chk(rdata_o == exp_w, "R1 order", int'(rdata_o), int'(exp_w));
      pend = 0;
      if (want && !empty_o) begin
        if (q.size() == 0) chk(0, "R1 extra word", 0, 0);
        else begin
          exp_w = q.pop_front();
          pend  = 1;
        end
      end
    end
    rd_en = want;
  endtask

  task automatic stream(input int n, input int wr_pct, input int rd_pct);
    wdone = 0;
    fork
      begin
        for (int i = 0; i < n; i++)
          wr_cycle($urandom_range(99) < wr_pct, DW'($urandom));
        wr_cycle(0, '0);
        wdone = 1;
      end
      begin
        while (!wdone || q.size() != 0 || pend) rd_cycle($urandom_range(99) < rd_pct);
        rd_cycle(0);
      end
    join
  endtask

  initial begin
    do_reset(0);
    // R12 reset state
    chk(empty_o == 1, "R12 empty", empty_o, 1);
    chk(full_o == 0, "R12 full", full_o, 0);
    chk(almost_empty_o == 1, "R12 almost_empty", almost_empty_o, 1);
    chk(almost_full_o == 0, "R12 almost_full", almost_full_o, 0);
    chk(rdata_o == 0, "R12 rdata", int'(rdata_o), 0);

    // fill with reader idle: R2, R9
    for (int i = 0; i < DEPTH; i++) begin
      wr_cycle(1, DW'(8'h10 + i));
      chk(almost_full_o == (i >= 12), "R9 almost_full level", almost_full_o, int'(i >= 12));
      chk(full_o == 0, "R2 full not early", full_o, 0);
    end
    wr_cycle(0, '0);
    chk(full_o == 1, "R2 full on time", full_o, 1);
    chk(almost_full_o == 1, "R9 almost_full at full", almost_full_o, 1);
    // R4 write while full
    wr_cycle(1, 8'hEE);
    wr_cycle(0, '0);
    chk(full_o == 1, "R4 still full", full_o, 1);

    repeat (6) @(negedge rclk);
    chk(empty_o == 0, "R11 empty released", empty_o, 0);
    chk(almost_empty_o == 0, "R10 almost_empty low", almost_empty_o, 0);
    chk(rdata_o == 0, "R6 no data without read", int'(rdata_o), 0);

    // drain: R10, R3, R1, R4
    for (int k = 0; k < DEPTH; k++) begin
      rd_cycle(1);
      chk(almost_empty_o == (k >= 13), "R10 almost_empty level", almost_empty_o, int'(k >= 13));
      chk(empty_o == 0, "R3 empty not early", empty_o, 0);
    end
    rd_cycle(0);
    chk(empty_o == 1, "R3 empty on time", empty_o, 1);
    repeat (8) @(negedge wclk);
    chk(full_o == 0, "R11 full released", full_o, 0);
    chk(almost_full_o == 0, "R9 almost_full released", almost_full_o, 0);
    repeat (8) @(negedge rclk);
    chk(empty_o == 1, "R4 ignored word not stored", empty_o, 1);

    // R5 read while empty
    rd_cycle(1);
    rd_cycle(0);
    chk(rdata_o == 8'h1F, "R5 rdata unchanged", int'(rdata_o), 8'h1F);
    chk(empty_o == 1, "R5 still empty", empty_o, 1);
    // R6 pull: word waits for read
    wr_cycle(1, 8'hA5);
    wr_cycle(0, '0);
    repeat (8) @(negedge rclk);
    chk(empty_o == 0, "R6 empty falls", empty_o, 0);
    chk(rdata_o == 8'h1F, "R6 rdata held", int'(rdata_o), 8'h1F);
    rd_cycle(1);
    rd_cycle(0);
    chk(rdata_o == 8'hA5, "R6 word after read", int'(rdata_o), 8'hA5);
    chk(empty_o == 1, "R3 empty after single", empty_o, 1);

    stream(300, 70, 70);
    stream(300, 90, 20);
    stream(300, 30, 90);

    // fall-through mode
    do_reset(1);
    chk(empty_o == 1, "R12 empty fwft", empty_o, 1);
    wr_cycle(1, 8'h3C);
    wr_cycle(0, '0);
    repeat (8) @(negedge rclk);
    chk(empty_o == 0, "R7 empty falls", empty_o, 0);
    chk(rdata_o == 8'h3C, "R7 word falls through", int'(rdata_o), 8'h3C);
    wr_cycle(1, 8'h4D);
    wr_cycle(0, '0);
    repeat (8) @(negedge rclk);
    chk(rdata_o == 8'h3C, "R8 hold without read", int'(rdata_o), 8'h3C);
    chk(almost_empty_o == 1, "R10 count includes output", almost_empty_o, 1);
    rd_cycle(1);
    rd_cycle(0);
    chk(rdata_o == 8'h4D, "R8 advance on read", int'(rdata_o), 8'h4D);
    rd_cycle(1);
    rd_cycle(0);
    chk(empty_o == 1, "R3 empty on consume fwft", empty_o, 1);

    stream(300, 70, 70);
    stream(300, 90, 20);
    stream(300, 30, 90);
    chk(q.size() == 0, "R1 all words out", q.size(), 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wclk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule